// File: doc/BRIEF.md
# PIO Setup and Register D2H FIS Generator

This block builds the device-to-host frames that one port posts into its receive area while it runs programmed-I/O and packet (ATAPI) commands. For each data request (DRQ) the device raises, it builds a 20-byte PIO Setup frame. It then holds until the data block has moved. When a command completes, it builds a 20-byte Register device-to-host frame. Both frames leave as a stream of single-byte writes, each with its byte offset in the receive area. The block also keeps the port's sticky interrupt status bits.

The interrupt flag inside a PIO Setup frame is not fixed. It is set for a non-packet read, and for any DRQ after the first one of the current command. Otherwise it is clear. A new command (`cmd_start`) rearms the first-DRQ tracking and clears the device error byte. For a packet command, the first DRQ only carries the command packet, so no data wait takes place. The setup-complete interrupt is held back until the data block finishes, and it is raised only if the frame's interrupt flag was set.

The byte stream uses valid/ready. While `wr_valid` is high and `wr_ready` is low, address and data are held. The two request inputs are also valid/ready. A request is accepted only in the idle state. The DRQ request takes priority over the completion request.

Top module: `pio_fis_gen`

## Requirements
- R1: The PIO Setup frame is written as 20 bytes, in order, to offsets PIO_BASE+0 to PIO_BASE+19 (default 0x20). Byte 0 is the type code 0x5F. Byte 2 is the status sampled with the request, and byte 3 is the device error byte held at acceptance. Bytes 16 and 17 hold the transfer count, low byte first. All other bytes are zero, apart from bit 6 of byte 1.
- R2: Bit 6 of byte 1 of a PIO Setup frame is 1 when the current command is a non-packet read (`cmd_write`=0, `cmd_atapi`=0). It is also 1 once a DRQ of the current command has completed. In all other cases it is 0.
- R3: `cmd_start` clears the first-DRQ record and the device error byte, and latches the direction and packet flags. `err_wr` loads `err_in` into the error byte. If both arrive in the same cycle, `cmd_start` wins.
- R4: For a packet command, the first DRQ finishes one cycle after its frame without waiting for `data_done`. It sets the first-DRQ record and does not raise the setup-complete bit.
- R5: In every other case, after the PIO Setup frame the block waits for `data_done`. It then sets the first-DRQ record. It sets interrupt bit 1 (setup complete) on the next cycle only if the frame's bit 6 was 1.
- R6: Interrupt bit 30 (task-file error) is set when the last byte of either frame type is accepted, if bit 0 of that frame's status byte is 1.
- R7: The Register D2H frame is written as 20 bytes to D2H_BASE+0 to D2H_BASE+19 (default 0x40). Byte 0 is 0x34 and byte 1 is 0x40, whatever the interrupt state. Byte 2 is `d2h_status`, byte 3 is the error byte, and the rest is zero. Interrupt bit 0 is set when its last byte is accepted.
- R8: Interrupt bits stay set until a 1 is written on the matching `irq_clear` bit. When a bit is set and cleared in the same cycle, the set wins.
- R9: `wr_addr` and `wr_data` stay stable while `wr_valid`=1 and `wr_ready`=0. `drq_ready` is 1 only when idle. `d2h_ready` is 1 only when idle and `drq_valid`=0.
- R10: After reset, `irq_status` is 0, `wr_valid` is 0 and `drq_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | New command accepted |
| cmd_write | input | 1 | Command moves data host to device |
| cmd_atapi | input | 1 | Command is a packet command |
| err_wr | input | 1 | Load device error byte |
| err_in | input | 8 | Device error value |
| drq_valid | input | 1 | DRQ request valid |
| drq_ready | output | 1 | DRQ request accepted |
| drq_status | input | 8 | Status byte for the PIO Setup frame |
| drq_count | input | 16 | Transfer byte count |
| data_done | input | 1 | Data block finished |
| d2h_valid | input | 1 | Completion frame request valid |
| d2h_ready | output | 1 | Completion request accepted |
| d2h_status | input | 8 | Status byte for the completion frame |
| wr_valid | output | 1 | Byte write valid |
| wr_ready | input | 1 | Byte write accepted |
| wr_addr | output | ADDR_W | Receive-area byte offset |
| wr_data | output | 8 | Byte value |
| irq_clear | input | IRQ_W | Write-1-to-clear mask |
| irq_status | output | IRQ_W | Sticky interrupt status |

## Verification
If the first-DRQ record is wrong, the bit 6 value of byte 1 in the next PIO Setup frame is wrong. Whether the setup-complete bit rises after `data_done` is also wrong. Both show within one frame. A wrong error byte shows as byte 3 of the next frame of either type. A wrong byte index or a wrong wait state shows at once as a misplaced or extra byte write, or as a ready that arrives too early. The bench model predicts every output on every cycle, so each fault is reported in the cycle where it first reaches a port.

// File: rtl/pio_fis_pkg.sv
package pio_fis_pkg;
  localparam int FIS_BYTES = 20;
  localparam logic [7:0] FIS_T_PIO = 8'h5F;
  localparam logic [7:0] FIS_T_D2H = 8'h34;
  localparam int IBIT_POS = 6;
  localparam int STS_ERR_BIT = 0;
  localparam int IRQ_DHRS = 0;
  localparam int IRQ_PSS = 1;
  localparam int IRQ_TFES = 30;
  localparam int CNT_LO_IDX = 16;
  localparam int CNT_HI_IDX = 17;

  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_WAIT} fsm_t;
  typedef enum logic {FK_PIO, FK_D2H} fis_kind_t;
endpackage

// File: rtl/fisgen_drq_track.sv
module fisgen_drq_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_write,
  input  logic       cmd_atapi,
  input  logic       err_wr,
  input  logic [7:0] err_in,
  input  logic       drq_complete,
  output logic       first_done,
  output logic       is_write,
  output logic       is_atapi,
  output logic [7:0] err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_done <= 1'b0;
      is_write   <= 1'b0;
      is_atapi   <= 1'b0;
      err_q      <= '0;
    end else if (cmd_start) begin
      first_done <= 1'b0;
      is_write   <= cmd_write;
      is_atapi   <= cmd_atapi;
      err_q      <= '0;
    end else begin
      if (drq_complete) first_done <= 1'b1;
      if (err_wr) err_q <= err_in;
    end
  end
endmodule

// File: rtl/fisgen_byte_sel.sv
module fisgen_byte_sel
  import pio_fis_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  fis_kind_t        kind,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       status,
  input  logic [7:0]       error,
  input  logic [15:0]      count,
  input  logic             ibit,
  output logic [7:0]       data
);
  always_comb begin
    data = '0;
    case (idx)
      IDX_W'(0): data = (kind == FK_PIO) ? FIS_T_PIO : FIS_T_D2H;
      IDX_W'(1): data[IBIT_POS] = ibit;
      IDX_W'(2): data = status;
      IDX_W'(3): data = error;
      IDX_W'(CNT_LO_IDX): data = count[7:0];
      IDX_W'(CNT_HI_IDX): data = count[15:8];
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/fisgen_irq_reg.sv
module fisgen_irq_reg #(
  parameter int IRQ_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic [IRQ_W-1:0] clr_vec,
  output logic [IRQ_W-1:0] q
);
  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[b] <= 1'b0;
      else if (set_vec[b]) q[b] <= 1'b1;
      else if (clr_vec[b]) q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_fis_gen.sv
module pio_fis_gen
  import pio_fis_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IRQ_W = 32,
  parameter logic [ADDR_W-1:0] PIO_BASE = 'h20,
  parameter logic [ADDR_W-1:0] D2H_BASE = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic              cmd_atapi,
  input  logic              err_wr,
  input  logic [7:0]        err_in,
  input  logic              drq_valid,
  output logic              drq_ready,
  input  logic [7:0]        drq_status,
  input  logic [15:0]       drq_count,
  input  logic              data_done,
  input  logic              d2h_valid,
  output logic              d2h_ready,
  input  logic [7:0]        d2h_status,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic [IRQ_W-1:0]  irq_clear,
  output logic [IRQ_W-1:0]  irq_status
);
  localparam int IDX_W = $clog2(FIS_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FIS_BYTES - 1);

  fsm_t             state_q;
  fis_kind_t        kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       sts_q;
  logic [7:0]       errl_q;
  logic [15:0]      cnt_q;
  logic             ibit_q;

  logic       first_done, is_write, is_atapi;
  logic [7:0] err_q;
  logic       wr_fire, last_fire, skip_data, drq_complete;
  logic [IRQ_W-1:0] irq_set;

  assign drq_ready = (state_q == ST_IDLE);
  assign d2h_ready = (state_q == ST_IDLE) && !drq_valid;
  assign wr_valid  = (state_q == ST_EMIT);
  assign wr_fire   = wr_valid && wr_ready;
  assign last_fire = wr_fire && (idx_q == IDX_LAST);
  assign skip_data = is_atapi && !first_done;
  assign drq_complete = (state_q == ST_WAIT) && (skip_data || data_done);
  assign wr_addr = ((kind_q == FK_PIO) ? PIO_BASE : D2H_BASE) + ADDR_W'(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= FK_PIO;
      idx_q   <= '0;
      sts_q   <= '0;
      errl_q  <= '0;
      cnt_q   <= '0;
      ibit_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          idx_q  <= '0;
          errl_q <= err_q;
          if (drq_valid) begin
            kind_q  <= FK_PIO;
            sts_q   <= drq_status;
            cnt_q   <= drq_count;
            ibit_q  <= first_done || (!is_atapi && !is_write);
            state_q <= ST_EMIT;
          end else if (d2h_valid) begin
            kind_q  <= FK_D2H;
            sts_q   <= d2h_status;
            cnt_q   <= '0;
            ibit_q  <= 1'b1;
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (wr_fire) begin
            if (idx_q == IDX_LAST) begin
              idx_q   <= '0;
              state_q <= (kind_q == FK_PIO) ? ST_WAIT : ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (drq_complete) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    irq_set = '0;
    irq_set[IRQ_DHRS] = last_fire && (kind_q == FK_D2H);
    irq_set[IRQ_PSS]  = drq_complete && ibit_q;
    irq_set[IRQ_TFES] = last_fire && sts_q[STS_ERR_BIT];
  end

  fisgen_drq_track u_track (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_atapi(cmd_atapi), .err_wr(err_wr), .err_in(err_in),
    .drq_complete(drq_complete), .first_done(first_done),
    .is_write(is_write), .is_atapi(is_atapi), .err_q(err_q)
  );

  fisgen_byte_sel #(.IDX_W(IDX_W)) u_bytes (
    .kind(kind_q), .idx(idx_q), .status(sts_q), .error(errl_q),
    .count(cnt_q), .ibit(ibit_q), .data(wr_data)
  );

  fisgen_irq_reg #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(irq_set), .clr_vec(irq_clear),
    .q(irq_status)
  );
endmodule

// File: rtl/pio_fis_gen_chk.sv
module pio_fis_gen_chk
  import pio_fis_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IRQ_W = 32,
  parameter logic [ADDR_W-1:0] PIO_BASE = 'h20,
  parameter logic [ADDR_W-1:0] D2H_BASE = 'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drq_ready,
  input logic              d2h_ready,
  input logic              data_done,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [IRQ_W-1:0]  irq_clear,
  input logic [IRQ_W-1:0]  irq_status
);
  localparam logic [ADDR_W-1:0] D2H_LAST = D2H_BASE + ADDR_W'(FIS_BYTES - 1);

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !drq_ready && !d2h_ready); // R9
  AST_PIO_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == PIO_BASE |-> wr_data == FIS_T_PIO); // R1
  AST_PSS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[IRQ_PSS]) |-> $past(data_done)); // R5
  AST_DHRS_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[IRQ_DHRS]) |-> $past(wr_valid && wr_ready && wr_addr == D2H_LAST)); // R7
  AST_STICKY_TFES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_status[IRQ_TFES]) && !$past(irq_clear[IRQ_TFES]) |-> irq_status[IRQ_TFES]); // R8
endmodule

bind pio_fis_gen pio_fis_gen_chk #(
  .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .PIO_BASE(PIO_BASE), .D2H_BASE(D2H_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .drq_ready(drq_ready), .d2h_ready(d2h_ready),
  .data_done(data_done), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .irq_clear(irq_clear),
  .irq_status(irq_status)
);

// File: tb/pio_fis_gen_tb.sv
module pio_fis_gen_tb;
  localparam int ADDR_W = 8;
  localparam int IRQ_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, cmd_write = 0, cmd_atapi = 0, err_wr = 0;
  logic [7:0] err_in = '0;
  logic drq_valid = 0, d2h_valid = 0, data_done = 0, wr_ready = 1;
  logic [7:0] drq_status = '0, d2h_status = '0;
  logic [15:0] drq_count = '0;
  logic [IRQ_W-1:0] irq_clear = '0;
  logic drq_ready, d2h_ready, wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [IRQ_W-1:0] irq_status;

  always #2.5 clk = ~clk;

  pio_fis_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_atapi(cmd_atapi), .err_wr(err_wr), .err_in(err_in),
    .drq_valid(drq_valid), .drq_ready(drq_ready), .drq_status(drq_status),
    .drq_count(drq_count), .data_done(data_done), .d2h_valid(d2h_valid),
    .d2h_ready(d2h_ready), .d2h_status(d2h_status), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_clear(irq_clear), .irq_status(irq_status)
  );

  int checks = 0, fails = 0;
  string scen = "reset";
  bit done_flag = 0;

  // reference model state: 0 idle, 1 emitting, 2 waiting for data
  int m_st = 0, m_idx = 0;
  bit m_d2h = 0, m_ib = 0, m_first = 0, m_wr = 0, m_atapi = 0;
  logic [7:0] m_sts = 0, m_err = 0, m_el = 0;
  logic [15:0] m_cnt = 0;
  logic [31:0] m_irq = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int i);
    if (i == 0) return m_d2h ? 8'h34 : 8'h5F;
    if (i == 1) return m_ib ? 8'h40 : 8'h00;
    if (i == 2) return m_sts;
    if (i == 3) return m_el;
    if (i == 16 && !m_d2h) return m_cnt[7:0];
    if (i == 17 && !m_d2h) return m_cnt[15:8];
    return 8'h00;
  endfunction

  task automatic compare();
    chk("R9 drq_ready", 64'(drq_ready), 64'(m_st == 0));
    chk("R9 d2h_ready", 64'(d2h_ready), 64'(m_st == 0 && !drq_valid));
    chk("R9 wr_valid", 64'(wr_valid), 64'(m_st == 1));
    if (m_st == 1) begin
      chk(m_d2h ? "R7 addr" : "R1 addr", 64'(wr_addr),
          64'((m_d2h ? 8'h40 : 8'h20) + m_idx));
      chk(m_d2h ? "R7 data" : (m_idx == 1 ? "R2 ibit" : "R1 data"),
          64'(wr_data), 64'(exp_byte(m_idx)));
    end
    chk("R5/R6/R7/R8 irq", 64'(irq_status), 64'(m_irq));
  endtask

  task automatic model_edge();
    logic [31:0] set = 0;
    case (m_st)
      0: if (drq_valid) begin
           m_d2h = 0; m_sts = drq_status; m_cnt = drq_count;
           m_ib = m_first || (!m_atapi && !m_wr); m_el = m_err; m_idx = 0; m_st = 1;
         end else if (d2h_valid) begin
           m_d2h = 1; m_sts = d2h_status; m_cnt = 0; m_ib = 1; m_el = m_err;
           m_idx = 0; m_st = 1;
         end
      1: if (wr_ready) begin
           if (m_idx == 19) begin
             if (m_sts[0]) set[30] = 1;
             if (m_d2h) begin set[0] = 1; m_st = 0; end
             else m_st = 2;
           end else m_idx++;
         end
      2: if ((m_atapi && !m_first) || data_done) begin
           if (m_ib) set[1] = 1;
           m_first = 1; m_st = 0;
         end
      default: ;
    endcase
    if (cmd_start) begin
      m_first = 0; m_err = 0; m_wr = cmd_write; m_atapi = cmd_atapi;
    end else if (err_wr) m_err = err_in;
    m_irq = (m_irq & ~irq_clear) | set;
  endtask

  task automatic tick();
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic start_cmd(bit w, bit a);
    cmd_start = 1; cmd_write = w; cmd_atapi = a;
    tick();
    cmd_start = 0;
  endtask

  task automatic emit_all(bit bp);
    int n = 0;
    while (m_st == 1) begin
      wr_ready = bp ? ((n % 3) != 1) : 1'b1;
      n++;
      tick();
    end
    wr_ready = 1;
  endtask

  task automatic send_drq(logic [7:0] s, logic [15:0] c, bit bp, int delay);
    bit acc;
    drq_valid = 1; drq_status = s; drq_count = c;
    do begin acc = (m_st == 0); tick(); end while (!acc);
    drq_valid = 0;
    emit_all(bp);
    if (m_st == 2 && m_atapi && !m_first) tick();
    else if (m_st == 2) begin
      repeat (delay) tick();
      data_done = 1; tick(); data_done = 0;
    end
    tick();
  endtask

  task automatic send_d2h(logic [7:0] s, bit bp);
    bit acc;
    d2h_valid = 1; d2h_status = s;
    do begin acc = (m_st == 0 && !drq_valid); tick(); end while (!acc);
    d2h_valid = 0;
    emit_all(bp);
    tick();
  endtask

  task automatic clear_irq(logic [31:0] m);
    irq_clear = m; tick(); irq_clear = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 irq", 64'(irq_status), 64'h0);
    chk("R10 wr_valid", 64'(wr_valid), 64'h0);
    chk("R10 drq_ready", 64'(drq_ready), 64'h1);
    rst_n = 1;
    tick();

    scen = "R2 R5 non-packet read";
    start_cmd(0, 0);
    send_drq(8'h58, 16'h0200, 0, 3);
    send_drq(8'h58, 16'h1234, 1, 0);
    send_d2h(8'h50, 0);
    clear_irq(32'hFFFF_FFFF);

    scen = "R2 R5 non-packet write";
    start_cmd(1, 0);
    send_drq(8'h58, 16'h0200, 0, 2);
    send_drq(8'h58, 16'hABCD, 1, 2);
    clear_irq(32'h2);

    scen = "R4 packet read";
    start_cmd(0, 1);
    send_drq(8'h58, 16'h000C, 0, 0);
    send_drq(8'h58, 16'h0800, 0, 4);
    clear_irq(32'hFFFF_FFFF);

    scen = "R4 packet write";
    start_cmd(1, 1);
    send_drq(8'h58, 16'h000C, 1, 0);
    send_drq(8'h58, 16'h0800, 0, 1);
    send_drq(8'h58, 16'h0801, 0, 1);

    scen = "R6 R8 error status and w1c";
    err_in = 8'h04; err_wr = 1; tick(); err_wr = 0;
    send_d2h(8'h51, 1);
    clear_irq(32'h4000_0000);
    start_cmd(0, 0);
    send_drq(8'h59, 16'h0010, 0, 1);
    irq_clear = 32'hFFFF_FFFF; tick(); irq_clear = 0;

    scen = "R3 error cleared by new command";
    err_in = 8'h84; err_wr = 1; tick(); err_wr = 0;
    err_in = 8'h11; err_wr = 1; cmd_start = 1; cmd_write = 1; cmd_atapi = 0;
    tick(); err_wr = 0; cmd_start = 0;
    send_drq(8'h58, 16'h0004, 0, 0);
    send_drq(8'h58, 16'h0004, 0, 0);
    send_d2h(8'h50, 0);

    scen = "R8 set wins over clear";
    start_cmd(0, 0);
    drq_valid = 1; drq_status = 8'h58; drq_count = 16'h0002;
    tick(); drq_valid = 0;
    emit_all(0);
    data_done = 1; irq_clear = 32'h2; tick(); data_done = 0; irq_clear = 0;
    tick();

    scen = "R9 drq priority over d2h";
    drq_valid = 1; d2h_valid = 1; drq_status = 8'h58; drq_count = 16'h0040;
    d2h_status = 8'h50;
    tick(); drq_valid = 0;
    emit_all(1);
    data_done = 1; tick(); data_done = 0;
    while (m_st != 1) tick();
    d2h_valid = 0;
    emit_all(0);
    repeat (3) tick();

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog [%s] actual=hung expected=done", scen);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule